// File: doc/BRIEF.md
# Three-Heads Coin Game Judge

This block scores a coin-tossing game one toss at a time. On every rising clock edge it samples a two-bit toss code and keeps a count of the heads seen in a row. A third consecutive head wins the game. A tail at any point loses it. When either happens, the count returns to zero so that the next game starts at once.

The win and lose indications belong to the transition on which the game is decided. Each is registered, so it shows as a one-cycle pulse in the cycle that follows the deciding edge. An "absent" toss code means nothing happened in that cycle: the count is held and no pulse is produced. The current head count is visible on an observation port.

Top module: `coin_streak_judge`

## Requirements
- R1: A synchronous active-high reset forces the head count to 0 and drives win and lose low in the cycle after the reset edge, whatever toss is applied.
- R2: The toss codes are 2'b00 absent, 2'b01 head and 2'b10 tail. A head taken with a count of 0 makes the count 1, and a head taken with a count of 1 makes it 2. Neither of these transitions raises win or lose.
- R3: A head taken with a count of 2 raises win for the next cycle and returns the count to 0.
- R4: A tail taken with any count raises lose for the next cycle and returns the count to 0.
- R5: An absent toss (2'b00) leaves the count unchanged and keeps both win and lose low in the next cycle.
- R6: The unused code 2'b11 behaves exactly like absent: the count holds and neither strobe rises.
- R7: Win and lose are never high in the same cycle. Each is high only in the single cycle that follows its deciding edge.
- R8: The head count is always one of 0, 1 or 2.
- R9: Starting from a count of 0, the tosses tail, head, head, tail give the outputs lose, none, none, lose and the counts 0, 1, 2, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| toss | input | 2 | Toss code: 00 absent, 01 head, 10 tail, 11 treated as absent |
| streak | output | 2 | Number of heads seen in a row (0 to 2) |
| win | output | 1 | One-cycle pulse after the third consecutive head |
| lose | output | 1 | One-cycle pulse after any tail |

## Verification
A wrong head count can stay hidden for as long as only absent codes arrive, because the outputs stay quiet. The fault appears on the first head after the corruption: it either gives a win one toss early or late, or moves the streak port to a value that disagrees with the count of heads applied since the last decision. The streak port exposes the count in the cycle right after each edge, so the bench compares it on every cycle. A missing return to zero after a win or a loss then shows up no later than the next head.

// File: rtl/coin_pkg.sv
package coin_pkg;

  localparam logic [1:0] TOSS_NONE = 2'b00;
  localparam logic [1:0] TOSS_HEAD = 2'b01;
  localparam logic [1:0] TOSS_TAIL = 2'b10;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic advance;
    logic winEv;
    logic loseEv;
  } ctrlT;

endpackage

// File: rtl/streak_ctrl.sv
module streak_ctrl
  import coin_pkg::*;
#(
  parameter int HEADS_TO_WIN = 3,
  localparam int CNT_W = $clog2(HEADS_TO_WIN)
) (
  input  logic [1:0]       toss,
  input  logic [CNT_W-1:0] streak,
  output ctrlT             ctrl
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HEADS_TO_WIN - 1);

  logic isHead;
  logic isTail;
  logic atLast;

  always_comb begin
    isHead = (toss == TOSS_HEAD);
    isTail = (toss == TOSS_TAIL);
    atLast = (streak == LAST);
    ctrl.winEv   = isHead && atLast;
    ctrl.advance = isHead && !atLast;
    ctrl.loseEv  = isTail;
  end

endmodule

// File: rtl/streak_dp.sv
module streak_dp
  import coin_pkg::*;
#(
  parameter int HEADS_TO_WIN = 3,
  localparam int CNT_W = $clog2(HEADS_TO_WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlT             ctrl,
  output logic [CNT_W-1:0] streak,
  output logic             win,
  output logic             lose
);

  always_ff @(posedge clk) begin
    if (rst) begin
      streak <= '0;
      win    <= 1'b0;
      lose   <= 1'b0;
    end else begin
      if (ctrl.winEv || ctrl.loseEv) begin
        streak <= '0;
      end else if (ctrl.advance) begin
        streak <= streak + CNT_W'(1);
      end
      win  <= ctrl.winEv;
      lose <= ctrl.loseEv;
    end
  end

endmodule

// File: rtl/coin_streak_judge.sv
module coin_streak_judge
  import coin_pkg::*;
#(
  parameter int HEADS_TO_WIN = 3,
  localparam int CNT_W = $clog2(HEADS_TO_WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       toss,
  output logic [CNT_W-1:0] streak,
  output logic             win,
  output logic             lose
);

  ctrlT ctrl;

  streak_ctrl #(.HEADS_TO_WIN(HEADS_TO_WIN)) u_ctrl (
    .toss   (toss),
    .streak (streak),
    .ctrl   (ctrl)
  );

  streak_dp #(.HEADS_TO_WIN(HEADS_TO_WIN)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .streak (streak),
    .win    (win),
    .lose   (lose)
  );

endmodule

// File: rtl/coin_streak_chk.sv
module coin_streak_chk
  import coin_pkg::*;
#(
  parameter int HEADS_TO_WIN = 3,
  localparam int CNT_W = $clog2(HEADS_TO_WIN)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       toss,
  input logic [CNT_W-1:0] streak,
  input logic             win,
  input logic             lose
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HEADS_TO_WIN - 1);

  // R2
  head_step_chk: assert property (@(posedge clk) disable iff (rst)
    (toss == TOSS_HEAD && streak != LAST) |=>
      (streak == $past(streak) + CNT_W'(1) && !win && !lose));

  // R3
  win_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (toss == TOSS_HEAD && streak == LAST) |=> (win && streak == '0));

  // R4
  lose_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (toss == TOSS_TAIL) |=> (lose && streak == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (toss == TOSS_NONE) |=> ($stable(streak) && !win && !lose));

  // R6
  spare_code_chk: assert property (@(posedge clk) disable iff (rst)
    (toss == 2'b11) |=> ($stable(streak) && !win && !lose));

  // R7
  strobe_mutex_chk: assert property (@(posedge clk) disable iff (rst)
    !(win && lose));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    streak <= LAST);

endmodule

bind coin_streak_judge coin_streak_chk #(.HEADS_TO_WIN(HEADS_TO_WIN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .toss   (toss),
  .streak (streak),
  .win    (win),
  .lose   (lose)
);

// File: tb/sim_coin_streak_judge.sv
`timescale 1ns/1ps
module sim_coin_streak_judge;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] toss = 2'b00;
  logic [1:0] streak;
  logic       win;
  logic       lose;

  int total = 0;
  int bad = 0;
  int mdl = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  coin_streak_judge u0 (
    .clk(clk), .rst(rst), .toss(toss),
    .streak(streak), .win(win), .lose(lose)
  );

  // expected {win, lose, next count} from the requirements
  function automatic logic [3:0] expectOf(input int cnt, input logic [1:0] t);
    if (t == 2'b01) begin
      if (cnt == 2) return {1'b1, 1'b0, 2'd0};
      return {1'b0, 1'b0, 2'(cnt + 1)};
    end
    if (t == 2'b10) return {1'b0, 1'b1, 2'd0};
    return {1'b0, 1'b0, 2'(cnt)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] t, input string req);
    logic [3:0] e;
    e = expectOf(mdl, t);
    toss = t;
    @(posedge clk);
    @(negedge clk);
    chk(streak == e[1:0], req, "streak", streak, e[1:0]);
    chk(win == e[3], req, "win", win, e[3]);
    chk(lose == e[2], req, "lose", lose, e[2]);
    chk(!(win && lose), "R7", "both strobes", {win, lose}, 0);
    chk(streak <= 2, "R8", "count range", streak, 2);
    mdl = e[1:0];
  endtask

  function automatic string tagOf(input int cnt, input logic [1:0] t);
    case (t)
      2'b01: return (cnt == 2) ? "R3" : "R2";
      2'b10: return "R4";
      2'b11: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4411));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(streak == 0, "R1", "streak after reset", streak, 0);
    chk(!win && !lose, "R1", "strobes after reset", {win, lose}, 0);
    rst = 1'b0;
    mdl = 0;

    // R9: tail head head tail
    step(2'b10, "R9");
    step(2'b01, "R9");
    step(2'b01, "R9");
    step(2'b10, "R9");

    // R3 with absent and spare codes between heads (R5, R6)
    step(2'b01, "R2");
    step(2'b00, "R5");
    step(2'b01, "R2");
    step(2'b11, "R6");
    step(2'b00, "R5");
    step(2'b01, "R3");
    step(2'b00, "R7");
    step(2'b01, "R2");
    step(2'b01, "R2");
    step(2'b10, "R4");

    // R1: reset with a deciding head pending
    step(2'b01, "R2");
    step(2'b01, "R2");
    rst = 1'b1;
    toss = 2'b01;
    @(posedge clk);
    @(negedge clk);
    chk(streak == 0, "R1", "streak on reset", streak, 0);
    chk(!win, "R1", "win on reset", win, 0);
    toss = 2'b10;
    @(posedge clk);
    @(negedge clk);
    chk(!lose, "R1", "lose on reset", lose, 0);
    rst = 1'b0;
    mdl = 0;

    // random mix weighted toward heads
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] t;
      int r;
      r = $urandom % 8;
      t = (r < 4) ? 2'b01 : (r < 6) ? 2'b00 : (r == 6) ? 2'b10 : 2'b11;
      step(t, tagOf(mdl, t));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule